// File: doc/BRIEF.md
# Receive Byte-to-Word Packer with End-of-Frame Padding

This block sits behind a serial infrared receiver and turns its stream of received bytes into 16-bit words held in a small first-in first-out store. Each word is filled low byte first, then high byte. When a word is complete it is committed to the store at once. The control logic drains words through a show-ahead read port and watches a fill level and full/empty flags.

A frame may end on an odd byte, which leaves half a word pending. In the slow serial mode the end-of-frame byte has a fixed code. If that code lands in the low half of a word, the high half is filled with zero and the word is committed in the same cycle. In the other modes the end-of-frame byte is an ordinary byte. There, a separate frame-end strobe flushes a pending low byte with a zero high byte.

A word that arrives while the store is full is dropped, and a sticky overflow flag records the loss. A clear strobe empties the store, discards any pending byte and clears the overflow flag. The clear takes priority over everything else in that cycle.

Top module: `rx_word_packer`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `fill_level` is 0 and `overflow` is 0.
- R2: The first byte of a word becomes bits [7:0] and the next byte becomes bits [15:8]. A lone first byte changes neither `fill_level` nor `empty`. The word is committed at the clock edge that samples its second byte.
- R3: With `sir_mode`=1, a byte equal to `EOF_CODE` (default 0xC1) that arrives while no low byte is pending commits the word {0x00, 0xC1} at the same edge. The same code arriving as a high byte is packed normally.
- R4: With `sir_mode`=0, a byte equal to `EOF_CODE` in the low half is held like any other byte and is not committed by itself.
- R5: `frame_end`=1 with `byte_valid`=0 and a low byte pending commits {0x00, low byte} at that edge. `frame_end` has no effect when no byte is pending or when `byte_valid` is 1 in the same cycle.
- R6: `rd_data` shows the oldest stored word. `rd_en`=1 while not empty pops it and lowers `fill_level` by one. `rd_en` while empty has no effect.
- R7: `full` is 1 exactly when `fill_level` equals `DEPTH`. A word committed while full is dropped, including in a cycle that also reads. The stored data is not overwritten. `overflow` is set and stays set until a clear.
- R8: `clear`=1 empties the store, clears `overflow` and discards a pending low byte. It overrides a byte, frame end or read in the same cycle.
- R9: A commit and a pop in the same cycle leave `fill_level` unchanged, and words come out in commit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Store clear strobe |
| sir_mode | input | 1 | 1 selects the slow serial mode with coded end-of-frame byte |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| frame_end | input | 1 | Frame-end strobe, flushes a pending low byte |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 16 | Oldest stored word (show-ahead) |
| fill_level | output | $clog2(DEPTH)+1 | Number of stored words |
| full | output | 1 | Store holds DEPTH words |
| empty | output | 1 | Store holds no words |
| overflow | output | 1 | Sticky: a word was dropped while full |

## Verification
Every result is due one clock edge after its stimulus. A completed word, a padded word, a pop, a clear and the overflow flag all appear together in `fill_level`, `rd_data` and the flags right after the edge that samples the input. The bench drives each stimulus at a falling edge and removes it at the next falling edge. It checks the outputs at that second falling edge, exactly one rising edge later. Cases where nothing should happen, such as a held byte, an empty pop, a full commit or a stray frame end, are checked in that same window. Pending-byte state is brought out by sending one more byte and checking the word it forms.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] low;
    } asm_state_t;
endpackage

// File: rtl/rxp_assembler.sv
module rxp_assembler
    import rxp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] EOF_CODE = 8'hC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sir_mode,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              frame_end,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o
);
    asm_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        push_o = 1'b0;
        word_o = '0;
        if (clear) begin
            st_d.pend = 1'b0;
        end else if (byte_valid) begin
            if (st_q.pend) begin
                push_o    = 1'b1;
                word_o    = {byte_data, st_q.low};
                st_d.pend = 1'b0;
            end else if (sir_mode && byte_data == EOF_CODE) begin
                push_o = 1'b1;
                word_o = {{BYTE_W{1'b0}}, byte_data};
            end else begin
                st_d.pend = 1'b1;
                st_d.low  = byte_data;
            end
        end else if (frame_end && st_q.pend) begin
            push_o    = 1'b1;
            word_o    = {{BYTE_W{1'b0}}, st_q.low};
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_sir_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !clear && sir_mode && !st_q.pend && byte_data == EOF_CODE)
            |-> (push_o && word_o[WORD_W-1:BYTE_W] == '0));

    p_nonsir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !clear && !sir_mode && !st_q.pend) |=> st_q.pend);

    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !st_q.pend);
endmodule

// File: rtl/rxp_fifo.sv
module rxp_fifo
    import rxp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [LVL_W-1:0]  fill_level,
    output logic              full,
    output logic              empty,
    output logic              overflow
);
    typedef struct packed {
        logic [LVL_W-1:0] wptr;
        logic [LVL_W-1:0] rptr;
        logic             ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    assign fill_level = st_q.wptr - st_q.rptr;
    assign full       = (fill_level == LVL_W'(DEPTH));
    assign empty      = (st_q.wptr == st_q.rptr);
    assign overflow   = st_q.ovf;
    assign rd_data    = mem_q[st_q.rptr[PTR_W-1:0]];

    always_comb begin
        st_d  = st_q;
        do_wr = push && !full && !clear;
        do_rd = rd_en && !empty && !clear;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_wr)        st_d.wptr = st_q.wptr + 1'b1;
            if (do_rd)        st_d.rptr = st_q.rptr + 1'b1;
            if (push && full) st_d.ovf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[st_q.wptr[PTR_W-1:0]] <= wr_word;
    end

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> $stable(st_q.wptr));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clear) |=> st_q.ovf);

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && !overflow));

    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !clear) |=> $stable(st_q.rptr));
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
    import rxp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter logic [7:0] EOF_CODE = 8'hC1,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sir_mode,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             frame_end,
    input  logic             rd_en,
    output logic [15:0]      rd_data,
    output logic [LVL_W-1:0] fill_level,
    output logic             full,
    output logic             empty,
    output logic             overflow
);
    logic              push_w;
    logic [WORD_W-1:0] word_w;

    rxp_assembler #(.EOF_CODE(EOF_CODE)) u_asm (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sir_mode(sir_mode),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_end(frame_end),
        .push_o(push_w), .word_o(word_w)
    );

    rxp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clear), .push(push_w), .wr_word(word_w),
        .rd_en(rd_en), .rd_data(rd_data), .fill_level(fill_level),
        .full(full), .empty(empty), .overflow(overflow)
    );

    p_commit_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_w && !full && !rd_en && !clear) |=> (fill_level == $past(fill_level) + 1'b1));
endmodule

// File: tb/rx_word_packer_bench.sv
module rx_word_packer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic clk = 0, rst_n = 0, clear = 0, sir_mode = 0, byte_valid = 0, frame_end = 0, rd_en = 0;
    logic [7:0] byte_data = 0;
    logic [15:0] rd_data;
    logic [LVL_W-1:0] fill_level;
    logic full, empty, overflow;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_word_packer #(.DEPTH(DEPTH)) u_rx_word_packer (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sir_mode(sir_mode),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_end(frame_end),
        .rd_en(rd_en), .rd_data(rd_data), .fill_level(fill_level),
        .full(full), .empty(empty), .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, release at the next; outputs then reflect one rising edge
    task automatic step(input logic bv, input logic [7:0] bd, input logic fe, input logic rd, input logic cl);
        @(negedge clk);
        byte_valid = bv; byte_data = bd; frame_end = fe; rd_en = rd; clear = cl;
        @(negedge clk);
        byte_valid = 0; frame_end = 0; rd_en = 0; clear = 0;
    endtask

    task automatic send(input logic [7:0] b); step(1, b, 0, 0, 0); endtask
    task automatic pop();                     step(0, 0, 0, 1, 0); endtask
    task automatic do_clear();                step(0, 0, 0, 0, 1); endtask

    task automatic t_reset();
        chk("R1 empty", 16'(empty), 16'd1);
        chk("R1 full", 16'(full), 16'd0);
        chk("R1 level", 16'(fill_level), 16'd0);
        chk("R1 overflow", 16'(overflow), 16'd0);
    endtask

    task automatic t_pack();
        do_clear(); sir_mode = 0;
        send(8'hA5);
        chk("R2 lone byte level", 16'(fill_level), 16'd0);
        chk("R2 lone byte empty", 16'(empty), 16'd1);
        send(8'h3C);
        chk("R2 level", 16'(fill_level), 16'd1);
        chk("R2 word", rd_data, 16'h3CA5);
    endtask

    task automatic t_sir_eof();
        do_clear(); sir_mode = 1;
        send(8'hC1);
        chk("R3 eof padded level", 16'(fill_level), 16'd1);
        chk("R3 eof padded word", rd_data, 16'h00C1);
        send(8'h11); send(8'hC1);
        chk("R3 eof high level", 16'(fill_level), 16'd2);
        pop();
        chk("R3 eof high word", rd_data, 16'hC111);
        sir_mode = 0;
    endtask

    task automatic t_nonsir();
        do_clear(); sir_mode = 0;
        send(8'hC1);
        chk("R4 eof held", 16'(fill_level), 16'd0);
        step(0, 0, 1, 0, 0);
        chk("R5 flush level", 16'(fill_level), 16'd1);
        chk("R5 flush word", rd_data, 16'h00C1);
        step(0, 0, 1, 0, 0);
        chk("R5 idle frame_end", 16'(fill_level), 16'd1);
        step(1, 8'h22, 1, 0, 0);
        chk("R5 frame_end with byte", 16'(fill_level), 16'd1);
        send(8'h33);
        pop();
        chk("R5 byte kept pending", rd_data, 16'h3322);
    endtask

    task automatic t_read();
        do_clear(); sir_mode = 0;
        send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        chk("R6 first word", rd_data, 16'h0201);
        pop();
        chk("R6 level after pop", 16'(fill_level), 16'd1);
        chk("R6 second word", rd_data, 16'h0403);
        pop();
        chk("R6 empty", 16'(empty), 16'd1);
        pop();
        chk("R6 pop on empty", 16'(fill_level), 16'd0);
        send(8'h05); send(8'h06);
        chk("R6 after empty pop", rd_data, 16'h0605);
    endtask

    task automatic t_full();
        do_clear(); sir_mode = 0;
        for (int i = 0; i < DEPTH; i++) begin
            send(8'(2*i)); send(8'(2*i+1));
        end
        chk("R7 full", 16'(full), 16'd1);
        chk("R7 no overflow yet", 16'(overflow), 16'd0);
        send(8'hEE);
        step(1, 8'hFF, 0, 1, 0);
        chk("R7 overflow set", 16'(overflow), 16'd1);
        chk("R7 level after drop", 16'(fill_level), 16'(DEPTH-1));
        chk("R7 not overwritten", rd_data, 16'h0302);
        pop();
        chk("R7 overflow sticky", 16'(overflow), 16'd1);
    endtask

    task automatic t_clear();
        send(8'h77);
        step(1, 8'h88, 0, 1, 1);
        chk("R8 level", 16'(fill_level), 16'd0);
        chk("R8 empty", 16'(empty), 16'd1);
        chk("R8 overflow", 16'(overflow), 16'd0);
        send(8'h44); send(8'h55);
        chk("R8 pending dropped", rd_data, 16'h5544);
    endtask

    task automatic t_simul();
        do_clear(); sir_mode = 0;
        send(8'h10); send(8'h20);
        send(8'h30);
        step(1, 8'h40, 0, 1, 0);
        chk("R9 level kept", 16'(fill_level), 16'd1);
        chk("R9 order", rd_data, 16'h4030);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_sir_eof();
        t_nonsir();
        t_read();
        t_full();
        t_clear();
        t_simul();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule